// File: doc/BRIEF.md
# Flash operation status reporter

This block produces the read-back status that a NOR-style flash presents while an internal program or erase is under way. It follows the operation state (idle, programming, sector erase, chip erase, erase suspended), keeps the address and data of the last accepted program write and the sector of the running sector erase, and times each operation with a down-counter loaded from a parameter.

Each read strobe returns, one cycle later, either the true array data (taken from an input port) or a status byte. In a status byte, bit 7 carries data polling, bit 6 toggles on every busy read and bit 2 toggles on reads of the suspended sector. An open-drain ready/busy line is modelled as an enable that is high while the line is pulled low. Command decoding, the array and the analog circuits are outside the block; it receives already decoded request pulses.

Top module: `flash_status_gen`

## Requirements
- R1: While programming, a read of the last loaded address returns bit 7 equal to the inverse of bit 7 of the loaded data; a read of any other address returns bit 7 = 0.
- R2: While a sector erase or chip erase runs, every read returns bit 7 = 0.
- R3: During a running program or erase, bit 6 of each read is the inverse of bit 6 of the previous read in the same operation; the toggle register is cleared at each operation start, so the first read of an operation returns bit 6 = 1.
- R4: While erase is suspended, a read whose sector field (the top SECTOR_W address bits) equals the suspended sector returns bit 7 = 1, bit 6 held at its last busy value and bit 2 inverted from the previous such access; a program request aimed at that sector also inverts the bit-2 register and starts no operation.
- R5: busy_oe is 1 for the whole of a running program or erase and 0 when idle or suspended.
- R6: A read strobe yields rd_valid one cycle later; when idle the returned word equals array_data as sampled with the strobe.
- R7: In every status byte, all bits other than 7, 6 and 2 are 0.
- R8: An operation with length parameter N keeps busy_oe high for N+1 clock cycles after its starting edge, ending when the down-counter reaches zero.
- R9: While suspended, a read of another sector returns true array data and does not change the bit-2 register.
- R10: Requests arriving while an operation runs are ignored; when idle, chip erase wins over sector erase, which wins over program.
- R11: Suspend is accepted only during sector erase and freezes the counter; resume continues it, so one suspension lengthens the busy time to N+2 busy cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_req | input | 1 | Program request pulse |
| serase_req | input | 1 | Sector erase request pulse |
| cerase_req | input | 1 | Chip erase request pulse |
| suspend_req | input | 1 | Erase suspend request pulse |
| resume_req | input | 1 | Erase resume request pulse |
| wr_addr | input | ADDR_W | Address of a program request or sector of an erase |
| wr_data | input | DATA_W | Data of a program request |
| rd_stb | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| array_data | input | DATA_W | True array contents at rd_addr |
| rd_data | output | DATA_W | Returned word, valid with rd_valid |
| rd_valid | output | 1 | Read result valid |
| busy_oe | output | 1 | Ready/busy pull-down enable |

## Verification
A program to an address whose data has bit 7 clear is polled at that address and at another one, which separates the address-matched polling bit from the toggle bit. A chip erase issued together with a program request at the same address separates the request priority and the erase polling value from the program value. A suspended sector erase is probed with hits, a miss between two hits and a program access to the suspended sector, so the bit-2 sequence reveals whether misses leave it alone and program accesses advance it. Busy lengths of each operation, with and without suspension, check the counter load and freeze.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_PROG   = 3'd1,
    OP_SERASE = 3'd2,
    OP_CERASE = 3'd3,
    OP_SUSP   = 3'd4
  } op_state_t;

  typedef enum logic [1:0] {
    RK_ARRAY = 2'd0,
    RK_PROG  = 2'd1,
    RK_ERASE = 2'd2,
    RK_SUSP  = 2'd3
  } rd_kind_t;

  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;
  localparam int SUSP_BIT = 2;

  // Status byte: only the three reporting positions may be non-zero.
  function automatic logic [7:0] status_byte(input logic poll, input logic tog,
                                             input logic stog);
    logic [7:0] b;
    b           = 8'h00;
    b[POLL_BIT] = poll;
    b[TOG_BIT]  = tog;
    b[SUSP_BIT] = stog;
    return b;
  endfunction

  function automatic logic is_running(input op_state_t s);
    return (s == OP_PROG) || (s == OP_SERASE) || (s == OP_CERASE);
  endfunction

endpackage

// File: rtl/op_sequencer.sv
module op_sequencer
  import flash_stat_pkg::*;
#(
  parameter int PROG_CYCLES   = 20,
  parameter int SERASE_CYCLES = 40,
  parameter int CERASE_CYCLES = 80
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      prog_req,
  input  logic      serase_req,
  input  logic      cerase_req,
  input  logic      suspend_req,
  input  logic      resume_req,
  output op_state_t state,
  output logic      op_start,
  output logic      prog_start,
  output logic      serase_start,
  output logic      done_evt
);

  localparam int MAX_A = (PROG_CYCLES > SERASE_CYCLES) ? PROG_CYCLES : SERASE_CYCLES;
  localparam int MAX_C = (MAX_A > CERASE_CYCLES) ? MAX_A : CERASE_CYCLES;
  localparam int CNT_W = $clog2(MAX_C + 1);

  logic [CNT_W-1:0] cnt;
  logic             idle;
  logic             cerase_start;

  always_comb begin
    idle         = (state == OP_IDLE);
    cerase_start = idle && cerase_req;
    serase_start = idle && !cerase_req && serase_req;
    prog_start   = idle && !cerase_req && !serase_req && prog_req;
    op_start     = cerase_start || serase_start || prog_start;
    done_evt     = is_running(state) && (cnt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= OP_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        OP_IDLE: begin
          if (cerase_start) begin
            state <= OP_CERASE;
            cnt   <= CNT_W'(CERASE_CYCLES);
          end else if (serase_start) begin
            state <= OP_SERASE;
            cnt   <= CNT_W'(SERASE_CYCLES);
          end else if (prog_start) begin
            state <= OP_PROG;
            cnt   <= CNT_W'(PROG_CYCLES);
          end
        end
        OP_PROG, OP_CERASE: begin
          if (done_evt) state <= OP_IDLE;
          else          cnt   <= cnt - 1'b1;
        end
        OP_SERASE: begin
          if (done_evt)         state <= OP_IDLE;
          else if (suspend_req) state <= OP_SUSP;
          else                  cnt   <= cnt - 1'b1;
        end
        OP_SUSP: begin
          if (resume_req) state <= OP_SERASE;
        end
        default: state <= OP_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/op_context.sv
module op_context #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int SECTOR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                prog_start,
  input  logic                serase_start,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [ADDR_W-1:0]   last_addr,
  output logic [DATA_W-1:0]   last_data,
  output logic [SECTOR_W-1:0] susp_sector
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_addr   <= '0;
      last_data   <= '0;
      susp_sector <= '0;
    end else begin
      if (prog_start) begin
        last_addr <= wr_addr;
        last_data <= wr_data;
      end
      if (serase_start) susp_sector <= wr_addr[ADDR_W-1 -: SECTOR_W];
    end
  end

endmodule

// File: rtl/toggle_unit.sv
module toggle_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic op_start,
  input  logic tog6_adv,
  input  logic tog2_adv,
  output logic t6_q,
  output logic t2_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t6_q <= 1'b0;
      t2_q <= 1'b0;
    end else if (op_start) begin
      t6_q <= 1'b0;
      t2_q <= 1'b0;
    end else begin
      if (tog6_adv) t6_q <= ~t6_q;
      if (tog2_adv) t2_q <= ~t2_q;
    end
  end

endmodule

// File: rtl/read_mux.sv
module read_mux
  import flash_stat_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int SECTOR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  op_state_t           state,
  input  logic                rd_stb,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [DATA_W-1:0]   array_data,
  input  logic [ADDR_W-1:0]   last_addr,
  input  logic                last_d7,
  input  logic [SECTOR_W-1:0] susp_sector,
  input  logic                t6_q,
  input  logic                t2_q,
  output logic                tog6_adv,
  output logic                tog2_rd,
  output logic [DATA_W-1:0]   rd_data,
  output logic                rd_valid,
  output rd_kind_t            rd_kind_q
);

  rd_kind_t    kind;
  logic [7:0]  sbyte;
  logic [DATA_W-1:0] word;
  logic        hit_last;
  logic        hit_susp;

  always_comb begin
    hit_last = (rd_addr == last_addr);
    hit_susp = (rd_addr[ADDR_W-1 -: SECTOR_W] == susp_sector);
    kind     = RK_ARRAY;
    sbyte    = 8'h00;
    unique case (state)
      OP_PROG: begin
        kind  = RK_PROG;
        sbyte = status_byte(hit_last ? ~last_d7 : 1'b0, ~t6_q, 1'b0);
      end
      OP_SERASE, OP_CERASE: begin
        kind  = RK_ERASE;
        sbyte = status_byte(1'b0, ~t6_q, 1'b0);
      end
      OP_SUSP: begin
        if (hit_susp) begin
          kind  = RK_SUSP;
          sbyte = status_byte(1'b1, t6_q, ~t2_q);
        end
      end
      default: kind = RK_ARRAY;
    endcase
    word     = (kind == RK_ARRAY) ? array_data : DATA_W'(sbyte);
    tog6_adv = rd_stb && ((kind == RK_PROG) || (kind == RK_ERASE));
    tog2_rd  = rd_stb && (kind == RK_SUSP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      rd_kind_q <= RK_ARRAY;
    end else begin
      rd_valid <= rd_stb;
      if (rd_stb) begin
        rd_data   <= word;
        rd_kind_q <= kind;
      end
    end
  end

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_stat_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int SECTOR_W      = 4,
  parameter int PROG_CYCLES   = 20,
  parameter int SERASE_CYCLES = 40,
  parameter int CERASE_CYCLES = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_req,
  input  logic              serase_req,
  input  logic              cerase_req,
  input  logic              suspend_req,
  input  logic              resume_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              busy_oe
);

  op_state_t           state;
  logic                op_start, prog_start, serase_start, done_evt;
  logic [ADDR_W-1:0]   last_addr;
  logic [DATA_W-1:0]   last_data;
  logic [SECTOR_W-1:0] susp_sector;
  logic                t6_q, t2_q;
  logic                tog6_adv, tog2_rd, tog2_wr, tog2_adv;
  rd_kind_t            rd_kind_q;

  op_sequencer #(
    .PROG_CYCLES(PROG_CYCLES), .SERASE_CYCLES(SERASE_CYCLES),
    .CERASE_CYCLES(CERASE_CYCLES)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .serase_req(serase_req),
    .cerase_req(cerase_req), .suspend_req(suspend_req), .resume_req(resume_req),
    .state(state), .op_start(op_start), .prog_start(prog_start),
    .serase_start(serase_start), .done_evt(done_evt)
  );

  op_context #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECTOR_W(SECTOR_W)) ctx_i (
    .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .serase_start(serase_start),
    .wr_addr(wr_addr), .wr_data(wr_data), .last_addr(last_addr),
    .last_data(last_data), .susp_sector(susp_sector)
  );

  // A program access aimed at the suspended sector advances the bit-2 register.
  assign tog2_wr  = prog_req && (state == OP_SUSP) &&
                    (wr_addr[ADDR_W-1 -: SECTOR_W] == susp_sector);
  assign tog2_adv = tog2_rd || tog2_wr;

  toggle_unit tog_i (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .tog6_adv(tog6_adv),
    .tog2_adv(tog2_adv), .t6_q(t6_q), .t2_q(t2_q)
  );

  read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECTOR_W(SECTOR_W)) mux_i (
    .clk(clk), .rst_n(rst_n), .state(state), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .array_data(array_data), .last_addr(last_addr), .last_d7(last_data[7]),
    .susp_sector(susp_sector), .t6_q(t6_q), .t2_q(t2_q), .tog6_adv(tog6_adv),
    .tog2_rd(tog2_rd), .rd_data(rd_data), .rd_valid(rd_valid), .rd_kind_q(rd_kind_q)
  );

  assign busy_oe = is_running(state);

endmodule

// File: rtl/flash_status_chk.sv
module flash_status_chk
  import flash_stat_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int PROG_CYCLES   = 20,
  parameter int CERASE_CYCLES = 80
) (
  input logic              clk,
  input logic              rst_n,
  input op_state_t         state,
  input logic              op_start,
  input logic              done_evt,
  input logic              rd_stb,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [ADDR_W-1:0] last_addr,
  input logic [DATA_W-1:0] last_data,
  input logic [DATA_W-1:0] array_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input rd_kind_t          rd_kind_q,
  input logic              busy_oe
);

  int   run_len;
  logic have_prev;
  logic prev6;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len   <= 0;
      have_prev <= 1'b0;
      prev6     <= 1'b0;
    end else begin
      if (op_start)                       run_len <= 0;
      else if (busy_oe && !done_evt)      run_len <= run_len + 1;
      if (op_start) have_prev <= 1'b0;
      else if (rd_valid && (rd_kind_q == RK_PROG || rd_kind_q == RK_ERASE)) begin
        // R3: successive busy reads alternate bit 6
        a_r3_toggle: assert (!have_prev || (rd_data[6] != prev6));
        have_prev <= 1'b1;
        prev6     <= rd_data[6];
      end
    end
  end

  a_r1_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && state == OP_PROG && rd_addr == last_addr) |=> (rd_data[7] != last_data[7]));

  a_r2_erase_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && (state == OP_SERASE || state == OP_CERASE)) |=> (rd_data[7] == 1'b0));

  a_r5_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> busy_oe);

  a_r5_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !busy_oe);

  a_r6_true_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && state == OP_IDLE) |=> (rd_valid && rd_data == $past(array_data)));

  a_r7_clean_status: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_kind_q != RK_ARRAY) |-> ((rd_data & ~DATA_W'(8'hC4)) == '0));

  a_r8_prog_len: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && state == OP_PROG) |-> (run_len == PROG_CYCLES));

  a_r8_cerase_len: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && state == OP_CERASE) |-> (run_len == CERASE_CYCLES));

endmodule

bind flash_status_gen flash_status_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES),
  .CERASE_CYCLES(CERASE_CYCLES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .state(state), .op_start(op_start), .done_evt(done_evt),
  .rd_stb(rd_stb), .rd_addr(rd_addr), .last_addr(last_addr), .last_data(last_data),
  .array_data(array_data), .rd_data(rd_data), .rd_valid(rd_valid),
  .rd_kind_q(rd_kind_q), .busy_oe(busy_oe)
);

// File: tb/flash_status_gen_tb_top.sv
module flash_status_gen_tb_top;

  localparam int AW = 16;
  localparam int DW = 8;
  localparam int PC = 12;
  localparam int SC = 16;
  localparam int CC = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          prog_req = 0, serase_req = 0, cerase_req = 0;
  logic          suspend_req = 0, resume_req = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_stb = 0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] array_data = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;
  logic          busy_oe;

  int checks = 0;
  int failures = 0;
  int busy_cnt = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  flash_status_gen #(
    .ADDR_W(AW), .DATA_W(DW), .SECTOR_W(4),
    .PROG_CYCLES(PC), .SERASE_CYCLES(SC), .CERASE_CYCLES(CC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .serase_req(serase_req),
    .cerase_req(cerase_req), .suspend_req(suspend_req), .resume_req(resume_req),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .array_data(array_data), .rd_data(rd_data), .rd_valid(rd_valid), .busy_oe(busy_oe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Monitor: pops the expected queue on each returned read.
  always @(negedge clk) begin
    if (busy_oe) busy_cnt++;
    if (rst_n && rd_valid) begin
      if (sb.size() == 0) check(0, "R6 unexpected rd_valid", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        check(rd_data == e.val, e.tag, rd_data, e.val);
      end
    end
  end

  task automatic do_read(input logic [AW-1:0] a, input logic [7:0] arr,
                         input logic [7:0] exp, input string tag);
    @(negedge clk);
    sb.push_back('{val: exp, tag: tag});
    rd_stb = 1; rd_addr = a; array_data = arr;
    @(negedge clk);
    rd_stb = 0;
  endtask

  task automatic start_op(input bit p, input bit s, input bit c,
                          input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    busy_cnt = 0;
    prog_req = p; serase_req = s; cerase_req = c; wr_addr = a; wr_data = d;
    @(negedge clk);
    prog_req = 0; serase_req = 0; cerase_req = 0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) suspend_req = 1; else resume_req = 1;
    @(negedge clk);
    suspend_req = 0; resume_req = 0;
  endtask

  task automatic wait_idle();
    while (busy_oe) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy_oe == 0 && rd_valid == 0, "R5 reset state", {busy_oe, rd_valid}, 0);
    rst_n = 1;
    do_read(16'h0100, 8'hA7, 8'hA7, "R6 idle true data");

    // Program 0x1234 <- 0x25 (bit 7 clear)
    start_op(1, 0, 0, 16'h1234, 8'h25);
    check(busy_oe == 1, "R5 busy during program", busy_oe, 1);
    do_read(16'h1234, 8'hFF, 8'hC0, "R1 R3 first program poll");
    do_read(16'h1234, 8'hFF, 8'h80, "R1 R3 second program poll");
    do_read(16'h0F00, 8'hFF, 8'h40, "R1 R7 other address poll");
    wait_idle();
    check(busy_cnt == PC + 1, "R8 program busy length", busy_cnt, PC + 1);
    do_read(16'h1234, 8'h5A, 8'h5A, "R6 true data after program");

    // Chip erase together with program: chip erase wins
    start_op(1, 0, 1, 16'h1234, 8'h25);
    do_read(16'h1234, 8'hFF, 8'h40, "R10 R2 R3 priority and erase poll");
    @(negedge clk); prog_req = 1; wr_addr = 16'h7777;
    @(negedge clk); prog_req = 0;
    do_read(16'h2222, 8'hFF, 8'h00, "R2 R3 erase second read");
    wait_idle();
    check(busy_cnt == CC + 1, "R8 chip erase busy length", busy_cnt, CC + 1);
    repeat (3) begin
      @(negedge clk);
      check(busy_oe == 0, "R10 ignored request not started", busy_oe, 0);
    end
    do_read(16'h2222, 8'h11, 8'h11, "R6 true data after erase");

    // Sector erase on sector 3 with suspend
    start_op(0, 1, 0, 16'h3000, 8'h00);
    do_read(16'h3010, 8'hFF, 8'h40, "R3 toggle cleared at start");
    pulse(0);
    check(busy_oe == 0, "R5 R11 released while suspended", busy_oe, 0);
    do_read(16'h3010, 8'hFF, 8'hC4, "R4 suspended hit 1");
    do_read(16'h3010, 8'hFF, 8'hC0, "R4 suspended hit 2");
    do_read(16'h5000, 8'h3C, 8'h3C, "R9 other sector true data");
    do_read(16'h3020, 8'hFF, 8'hC4, "R9 no toggle on miss");
    @(negedge clk); prog_req = 1; wr_addr = 16'h3ABC; wr_data = 8'h00;
    @(negedge clk); prog_req = 0;
    check(busy_oe == 0, "R4 program to suspended sector not started", busy_oe, 0);
    do_read(16'h3010, 8'hFF, 8'hC4, "R4 program access advanced bit 2");
    @(negedge clk); prog_req = 1; wr_addr = 16'h5000;
    @(negedge clk); prog_req = 0;
    check(busy_oe == 0, "R4 program while suspended not started", busy_oe, 0);
    pulse(1);
    check(busy_oe == 1, "R11 resume busy again", busy_oe, 1);
    do_read(16'h3010, 8'hFF, 8'h00, "R3 R11 toggle continues after resume");
    wait_idle();
    check(busy_cnt == SC + 2, "R11 counter frozen during suspend", busy_cnt, SC + 2);
    do_read(16'h3010, 8'h66, 8'h66, "R6 true data after sector erase");

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R6 all reads returned", sb.size(), 0);
    finish_run();
  end

endmodule